// File: doc/BRIEF.md
# USB OTG Core Register Bridge

This block connects a 32-bit peripheral register bus to the register port of an embedded USB OTG controller core. Any access below the wrapper base reaches the core at its original width. Accesses in the lowest 32 bytes go through unchanged. In the sparse per-endpoint FIFO region, the bridge folds the address so that the FIFO ports occupy consecutive words of the core's address space.

The top 1 KiB of the bus window holds the wrapper's own registers: a revision word, a system configuration word with a soft-reset bit, a status word that always reports reset done, a two-bit interface select, a simulation-enable word that must stay clear, and a force-standby bit. The stored interface select and standby values drive outputs toward the PHY side.

The core's interrupt events pass through a gate. VBUS events and session events are dropped. Every other event copies its level onto the system interrupt line.

The bus side accepts a request when `bus_req` and `bus_ready` are both high. The core request appears one cycle after acceptance. The response (`rsp_valid`, `rsp_rdata`, `rsp_err`) appears two cycles after acceptance.

Top module: `otg_reg_bridge`

## Requirements
- R1: A bus access at an address below 0x20 is issued to the core one cycle after acceptance, with the same address, size code (0 = byte, 1 = halfword, 2 = word), write flag and write data. A core read returns the core's data two cycles after acceptance.
- R2: A bus access at an address from 0x20 up to 0x3FF reaches the core at address 0x20 + ((addr >> 3) & 0x3C). The core address therefore never exceeds 0x5C.
- R3: A word read at offset 0x400 returns the REV_VALUE parameter. A write there is flagged as an error.
- R4: A word write at offset 0x404 stores the written value ANDed with 0x301F, and a later read returns that value.
- R5: A word write at 0x404 with bit 1 set clears the interface select and the standby bit at the same clock edge that stores the configuration.
- R6: A word read at offset 0x408 returns 1. A write there is flagged as an error.
- R7: A word write at 0x40C keeps only bits [1:0] as the interface select, and a word write at 0x414 keeps only bit 0 as the standby bit. Both values read back and appear on `phy_if_sel` and `standby_req`.
- R8: At offset 0x410, a word write with bit 0 set is flagged as an error. A word write with bit 0 clear is accepted. The register always reads 0.
- R9: A byte or halfword access at or above 0x400, or a word access to any wrapper offset other than the six listed, returns `rsp_err` = 1 with read data 0. Such an access changes no wrapper state.
- R10: A core event with source code 0 (VBUS) or 1 (session) leaves `irq` unchanged. An event with any other source code sets `irq` to the event level at the next clock edge.
- R11: In the cycle after a soft-reset write is accepted, `bus_ready` is low and no request is accepted. A request held high through that cycle is accepted one cycle later.
- R12: Every accepted access produces exactly one response two cycles after acceptance. Writes return read data 0.
- R13: After reset the configuration, interface select, standby bit and `irq` are 0, `bus_ready` is 1 and `rsp_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_req | input | 1 | Bus access request |
| bus_ready | output | 1 | Bridge can accept a request |
| bus_we | input | 1 | 1 = write |
| bus_size | input | 2 | 0 byte, 1 halfword, 2 word |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response strobe |
| rsp_rdata | output | 32 | Read data |
| rsp_err | output | 1 | Access error |
| core_req | output | 1 | Core register access |
| core_we | output | 1 | Core write flag |
| core_size | output | 2 | Core access size |
| core_addr | output | CORE_AW | Core register address |
| core_wdata | output | 32 | Core write data |
| core_rdata | input | 32 | Core read data, valid while `core_req` is high |
| core_evt | input | 1 | Core interrupt event strobe |
| core_evt_src | input | SRC_W | Event source code |
| core_evt_level | input | 1 | Interrupt level carried by the event |
| irq | output | 1 | System interrupt line |
| phy_if_sel | output | 2 | Stored interface select |
| standby_req | output | 1 | Stored force-standby bit |

## Verification
The assertions assume three things about the core side. The core's read data is valid in the cycle `core_req` is high. Event strobes are single-cycle. `bus_req` may stay high while `bus_ready` is low, and the bus does not count a request as taken in that cycle.

The stimulus respects all three. It drives every input on the falling edge. It holds a request across the soft-reset hold-off cycle. It supplies core read data from a combinational stub keyed on `core_addr`. It sends event pulses only between bus accesses.

// File: rtl/otg_bridge_pkg.sv
package otg_bridge_pkg;
  typedef enum logic [1:0] {SZ_BYTE = 2'd0, SZ_HALF = 2'd1, SZ_WORD = 2'd2} acc_size_e;
  typedef enum logic [2:0] {
    WSEL_NONE, WSEL_REV, WSEL_SYSCFG, WSEL_STATUS, WSEL_IFSEL, WSEL_SIMEN, WSEL_STDBY
  } wsel_e;
  localparam int unsigned EVT_VBUS    = 0;
  localparam int unsigned EVT_SESSION = 1;
endpackage

// File: rtl/otg_addr_map.sv
module otg_addr_map
  import otg_bridge_pkg::*;
#(
  parameter int ADDR_W    = 11,
  parameter int CORE_AW   = 8,
  parameter int LOW_LIMIT = 32,
  parameter int WRAP_BASE = 1024
) (
  input  logic [ADDR_W-1:0]  addr,
  output logic               to_core,
  output logic [CORE_AW-1:0] core_addr,
  output wsel_e              wsel
);
  localparam logic [ADDR_W-1:0] A_REV    = ADDR_W'(WRAP_BASE);
  localparam logic [ADDR_W-1:0] A_SYSCFG = ADDR_W'(WRAP_BASE + 4);
  localparam logic [ADDR_W-1:0] A_STATUS = ADDR_W'(WRAP_BASE + 8);
  localparam logic [ADDR_W-1:0] A_IFSEL  = ADDR_W'(WRAP_BASE + 12);
  localparam logic [ADDR_W-1:0] A_SIMEN  = ADDR_W'(WRAP_BASE + 16);
  localparam logic [ADDR_W-1:0] A_STDBY  = ADDR_W'(WRAP_BASE + 20);

  logic [ADDR_W-1:0] folded;

  always_comb begin
    to_core = (addr < ADDR_W'(WRAP_BASE));
    folded  = (addr >> 3) & ADDR_W'(32'h3C);
    if (addr < ADDR_W'(LOW_LIMIT))
      core_addr = CORE_AW'(addr);
    else
      core_addr = CORE_AW'(32'h20) + CORE_AW'(folded);
    unique case (addr)
      A_REV:    wsel = WSEL_REV;
      A_SYSCFG: wsel = WSEL_SYSCFG;
      A_STATUS: wsel = WSEL_STATUS;
      A_IFSEL:  wsel = WSEL_IFSEL;
      A_SIMEN:  wsel = WSEL_SIMEN;
      A_STDBY:  wsel = WSEL_STDBY;
      default:  wsel = WSEL_NONE;
    endcase
  end
endmodule

// File: rtl/otg_wrap_regs.sv
module otg_wrap_regs
  import otg_bridge_pkg::*;
#(
  parameter int          DW          = 32,
  parameter logic [31:0] REV_VALUE   = 32'h0000_0033,
  parameter logic [31:0] SYSCFG_MASK = 32'h0000_301F
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          acc,
  input  logic          we,
  input  logic [1:0]    size,
  input  wsel_e         wsel,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic          err,
  output logic          srst_fire,
  output logic [1:0]    ifsel,
  output logic          stdby
);
  logic [DW-1:0] sysconfig;
  logic          bad_ro, bad_sim;

  always_comb begin
    bad_ro    = we && (wsel == WSEL_REV || wsel == WSEL_STATUS);
    bad_sim   = we && (wsel == WSEL_SIMEN) && wdata[0];
    err       = acc && (size != SZ_WORD || wsel == WSEL_NONE || bad_ro || bad_sim);
    srst_fire = acc && we && !err && wsel == WSEL_SYSCFG && wdata[1];
    case (wsel)
      WSEL_REV:    rdata = DW'(REV_VALUE);
      WSEL_SYSCFG: rdata = sysconfig;
      WSEL_STATUS: rdata = DW'(1);
      WSEL_IFSEL:  rdata = DW'(ifsel);
      WSEL_STDBY:  rdata = DW'(stdby);
      default:     rdata = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sysconfig <= '0;
      ifsel     <= '0;
      stdby     <= 1'b0;
    end else if (acc && we && !err) begin
      case (wsel)
        WSEL_SYSCFG: begin
          sysconfig <= wdata & DW'(SYSCFG_MASK);
          if (wdata[1]) begin
            ifsel <= '0;
            stdby <= 1'b0;
          end
        end
        WSEL_IFSEL: ifsel <= wdata[1:0];
        WSEL_STDBY: stdby <= wdata[0];
        default: ;
      endcase
    end
  end

  assert_err_nostate_R9: assert property (@(posedge clk) disable iff (rst)
    (acc && err) |=> ($stable(sysconfig) && $stable(ifsel) && $stable(stdby)));
  assert_srst_clears_R5: assert property (@(posedge clk) disable iff (rst)
    srst_fire |=> (ifsel == 2'b00 && !stdby));
  assert_cfg_masked_R4: assert property (@(posedge clk) disable iff (rst)
    (sysconfig & ~DW'(SYSCFG_MASK)) == '0);
endmodule

// File: rtl/otg_irq_gate.sv
module otg_irq_gate
  import otg_bridge_pkg::*;
#(
  parameter int SRC_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             evt,
  input  logic [SRC_W-1:0] src,
  input  logic             level,
  output logic             irq
);
  logic filtered;

  always_comb
    filtered = (src == SRC_W'(EVT_VBUS)) || (src == SRC_W'(EVT_SESSION));

  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else if (evt && !filtered) irq <= level;
  end

  assert_filter_R10: assert property (@(posedge clk) disable iff (rst)
    (evt && src <= SRC_W'(EVT_SESSION)) |=> $stable(irq));
endmodule

// File: rtl/otg_reg_bridge.sv
module otg_reg_bridge
  import otg_bridge_pkg::*;
#(
  parameter int          ADDR_W    = 11,
  parameter int          CORE_AW   = 8,
  parameter int          SRC_W     = 3,
  parameter logic [31:0] REV_VALUE = 32'h0000_0033
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               bus_req,
  output logic               bus_ready,
  input  logic               bus_we,
  input  logic [1:0]         bus_size,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [31:0]        bus_wdata,
  output logic               rsp_valid,
  output logic [31:0]        rsp_rdata,
  output logic               rsp_err,
  output logic               core_req,
  output logic               core_we,
  output logic [1:0]         core_size,
  output logic [CORE_AW-1:0] core_addr,
  output logic [31:0]        core_wdata,
  input  logic [31:0]        core_rdata,
  input  logic               core_evt,
  input  logic [SRC_W-1:0]   core_evt_src,
  input  logic               core_evt_level,
  output logic               irq,
  output logic [1:0]         phy_if_sel,
  output logic               standby_req
);
  localparam int DW = 32;

  logic               acc, wrap_acc, to_core, w_err, srst_fire, srst_busy;
  logic [CORE_AW-1:0] map_addr;
  wsel_e              wsel;
  logic [DW-1:0]      w_rdata;
  logic               s1_valid, s1_core, s1_err;
  logic [DW-1:0]      s1_rdata;

  assign bus_ready = !srst_busy;
  assign acc       = bus_req && bus_ready;
  assign wrap_acc  = acc && !to_core;

  otg_addr_map #(.ADDR_W(ADDR_W), .CORE_AW(CORE_AW)) u_map (
    .addr(bus_addr), .to_core(to_core), .core_addr(map_addr), .wsel(wsel)
  );

  otg_wrap_regs #(.DW(DW), .REV_VALUE(REV_VALUE)) u_regs (
    .clk(clk), .rst(rst), .acc(wrap_acc), .we(bus_we), .size(bus_size),
    .wsel(wsel), .wdata(bus_wdata), .rdata(w_rdata), .err(w_err),
    .srst_fire(srst_fire), .ifsel(phy_if_sel), .stdby(standby_req)
  );

  otg_irq_gate #(.SRC_W(SRC_W)) u_irq (
    .clk(clk), .rst(rst), .evt(core_evt), .src(core_evt_src),
    .level(core_evt_level), .irq(irq)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      core_req   <= 1'b0;
      core_we    <= 1'b0;
      core_size  <= 2'b00;
      core_addr  <= '0;
      core_wdata <= '0;
      s1_valid   <= 1'b0;
      s1_core    <= 1'b0;
      s1_err     <= 1'b0;
      s1_rdata   <= '0;
      srst_busy  <= 1'b0;
      rsp_valid  <= 1'b0;
      rsp_rdata  <= '0;
      rsp_err    <= 1'b0;
    end else begin
      core_req <= acc && to_core;
      if (acc && to_core) begin
        core_we    <= bus_we;
        core_size  <= bus_size;
        core_addr  <= map_addr;
        core_wdata <= bus_wdata;
      end
      s1_valid  <= acc;
      s1_core   <= acc && to_core && !bus_we;
      s1_err    <= wrap_acc && w_err;
      s1_rdata  <= (wrap_acc && !bus_we && !w_err) ? w_rdata : '0;
      srst_busy <= srst_fire;
      rsp_valid <= s1_valid;
      rsp_rdata <= s1_core ? core_rdata : s1_rdata;
      rsp_err   <= s1_err;
    end
  end

  assert_window_R2: assert property (@(posedge clk) disable iff (rst)
    core_req |-> (core_addr <= CORE_AW'(32'h5C)));
  assert_holdoff_R11: assert property (@(posedge clk) disable iff (rst)
    !bus_ready |=> !core_req);
  assert_latency_R12: assert property (@(posedge clk) disable iff (rst)
    core_req |=> rsp_valid);
  assert_err_only_wrap_R9: assert property (@(posedge clk) disable iff (rst)
    core_req |=> !rsp_err);
endmodule

// File: tb/otg_reg_bridge_test.sv
`timescale 1ns/1ps
module otg_reg_bridge_test;
  logic clk = 1'b0, rst = 1'b1;
  logic bus_req = 0, bus_we = 0;
  logic [1:0] bus_size = 0;
  logic [10:0] bus_addr = 0;
  logic [31:0] bus_wdata = 0;
  logic bus_ready, rsp_valid, rsp_err, core_req, core_we, irq, standby_req;
  logic [31:0] rsp_rdata, core_wdata, core_rdata;
  logic [1:0] core_size, phy_if_sel;
  logic [7:0] core_addr;
  logic core_evt = 0, core_evt_level = 0;
  logic [2:0] core_evt_src = 0;

  int vectors = 0, miscompares = 0;
  int m_syscfg = 0, m_ifsel = 0, m_stdby = 0;
  logic m_irq;

  always #2.5 clk = ~clk;

  assign core_rdata = core_req ? (32'hC0DE_0000 | {24'h0, core_addr}) : 32'hDEAD_BEEF;

  otg_reg_bridge uut (.*);

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  always @(posedge clk)
    if (rst) m_irq <= 1'b0;
    else if (core_evt && core_evt_src > 3'd1) m_irq <= core_evt_level;

  always @(negedge clk)
    if (!rst) chk(irq === m_irq, "R10 irq", {31'h0, irq}, {31'h0, m_irq});

  function automatic void model(input bit we, input logic [1:0] sz, input int a,
                                input logic [31:0] wd, output bit core, output int caddr,
                                output bit err, output logic [31:0] rd);
    int off;
    core = (a < 1024); err = 0; rd = 0; caddr = 0;
    if (core) begin
      caddr = (a < 32) ? a : 32 + ((a >> 3) & 60);
      if (!we) rd = 32'hC0DE_0000 | caddr;
      return;
    end
    off = a - 1024;
    err = (sz != 2) || !(off inside {0, 4, 8, 12, 16, 20});
    if (we && (off == 0 || off == 8 || (off == 16 && wd[0]))) err = 1;
    if (err) return;
    if (we) begin
      if (off == 4) begin
        if (wd[1]) begin m_ifsel = 0; m_stdby = 0; end
        m_syscfg = wd & 32'h301F;
      end
      if (off == 12) m_ifsel = wd & 3;
      if (off == 20) m_stdby = wd & 1;
    end else begin
      case (off)
        0: rd = 32'h33;
        4: rd = m_syscfg;
        8: rd = 1;
        12: rd = m_ifsel;
        20: rd = m_stdby;
        default: rd = 0;
      endcase
    end
  endfunction

  task automatic access(input bit we, input logic [1:0] sz, input int a,
                        input logic [31:0] wd, input string req);
    bit core, err; int caddr; logic [31:0] rd;
    @(negedge clk);
    bus_req = 1; bus_we = we; bus_size = sz; bus_addr = 11'(a); bus_wdata = wd;
    while (!bus_ready) @(negedge clk);
    model(we, sz, a, wd, core, caddr, err, rd);
    @(negedge clk);
    bus_req = 0;
    chk(core_req === core, {req, " core_req"}, {31'h0, core_req}, {31'h0, core});
    chk(rsp_valid === 1'b0, "R12 early rsp", {31'h0, rsp_valid}, 0);
    if (core) begin
      chk(core_addr === 8'(caddr), {req, " core_addr"}, {24'h0, core_addr}, caddr);
      chk(core_we === we && core_size === sz, {req, " core we/size"},
          {29'h0, core_we, core_size}, {29'h0, we, sz});
      if (we) chk(core_wdata === wd, {req, " core_wdata"}, core_wdata, wd);
    end
    @(negedge clk);
    chk(rsp_valid === 1'b1, "R12 rsp_valid", {31'h0, rsp_valid}, 1);
    chk(rsp_err === err, {req, " rsp_err"}, {31'h0, rsp_err}, {31'h0, err});
    chk(rsp_rdata === rd, {req, " rsp_rdata"}, rsp_rdata, rd);
    chk(phy_if_sel === 2'(m_ifsel) && standby_req === m_stdby[0], {req, " phy outs"},
        {29'h0, phy_if_sel, standby_req}, {29'h0, 2'(m_ifsel), m_stdby[0]});
  endtask

  task automatic evt(input int src, input bit lvl);
    @(negedge clk);
    core_evt = 1; core_evt_src = 3'(src); core_evt_level = lvl;
    @(negedge clk);
    core_evt = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog expired actual=%h expected=%h", 0, 1);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    bit c, e; int ca; logic [31:0] r;
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 0;
    @(negedge clk);
    // R13 reset state
    chk(bus_ready === 1 && rsp_valid === 0, "R13 ready/rsp", {30'h0, bus_ready, rsp_valid}, 2);
    chk(irq === 0 && phy_if_sel === 0 && standby_req === 0, "R13 outs",
        {28'h0, irq, phy_if_sel, standby_req}, 0);
    access(0, 2, 12'h404, 0, "R13 sysconfig reset");
    // R1 low window
    access(0, 0, 12'h004, 0, "R1 byte read");
    access(1, 1, 12'h00C, 32'h1234, "R1 half write");
    access(0, 2, 12'h01C, 0, "R1 word read");
    // R2 FIFO window
    access(0, 2, 12'h020, 0, "R2 fifo lo");
    access(0, 2, 12'h3F8, 0, "R2 fifo top");
    access(1, 2, 12'h100, 32'hA5A5_0001, "R2 fifo write");
    access(0, 0, 12'h0A3, 0, "R2 fifo byte");
    // R3, R6
    access(0, 2, 12'h400, 0, "R3 revision");
    access(1, 2, 12'h400, 32'hFFFF, "R3 ro write");
    access(0, 2, 12'h408, 0, "R6 status");
    access(1, 2, 12'h408, 0, "R6 ro write");
    // R4, R7
    access(1, 2, 12'h404, 32'hFFFF_FFFD, "R4 cfg write");
    access(0, 2, 12'h404, 0, "R4 cfg read");
    access(1, 2, 12'h40C, 32'hFFFF_FFFF, "R7 ifsel write");
    access(1, 2, 12'h414, 32'hFFFF_FFFE, "R7 stdby write even");
    access(1, 2, 12'h414, 32'h0000_0003, "R7 stdby write");
    access(0, 2, 12'h40C, 0, "R7 ifsel read");
    access(0, 2, 12'h414, 0, "R7 stdby read");
    // R8
    access(1, 2, 12'h410, 32'h1, "R8 sim enable");
    access(1, 2, 12'h410, 32'h2, "R8 sim clear");
    access(0, 2, 12'h410, 0, "R8 sim read");
    // R9
    access(0, 0, 12'h404, 0, "R9 byte wrap");
    access(1, 1, 12'h40C, 32'h0, "R9 half write");
    access(1, 0, 12'h414, 32'h0, "R9 byte write");
    access(0, 2, 12'h418, 0, "R9 undefined");
    access(1, 2, 12'h7FC, 32'h1, "R9 undefined write");
    access(0, 2, 12'h40D, 0, "R9 misaligned");
    // R5 + R11: soft reset followed by a held request
    @(negedge clk);
    bus_req = 1; bus_we = 1; bus_size = 2; bus_addr = 11'h404; bus_wdata = 32'h2;
    model(1, 2, 12'h404, 32'h2, c, ca, e, r);
    @(negedge clk);
    bus_we = 0; bus_addr = 11'h010;
    chk(bus_ready === 0, "R11 ready low", {31'h0, bus_ready}, 0);
    chk(phy_if_sel === 0 && standby_req === 0, "R5 cleared",
        {29'h0, phy_if_sel, standby_req}, 0);
    @(negedge clk);
    chk(core_req === 0, "R11 no accept", {31'h0, core_req}, 0);
    chk(rsp_valid === 1 && rsp_err === 0, "R5 rsp", {30'h0, rsp_valid, rsp_err}, 2);
    chk(bus_ready === 1, "R11 ready back", {31'h0, bus_ready}, 1);
    @(negedge clk);
    bus_req = 0;
    chk(core_req === 1 && core_addr === 8'h10, "R11 late accept", {23'h0, core_req, core_addr}, 32'h110);
    @(negedge clk);
    chk(rsp_valid === 1 && rsp_rdata === 32'hC0DE_0010, "R11 late rsp", rsp_rdata, 32'hC0DE_0010);
    access(0, 2, 12'h404, 0, "R5 cfg after srst");
    access(0, 2, 12'h40C, 0, "R5 ifsel after srst");
    // R10
    evt(2, 1);
    chk(irq === 1, "R10 pass high", {31'h0, irq}, 1);
    evt(0, 0);
    chk(irq === 1, "R10 vbus ignored", {31'h0, irq}, 1);
    evt(1, 0);
    chk(irq === 1, "R10 session ignored", {31'h0, irq}, 1);
    evt(5, 0);
    chk(irq === 0, "R10 pass low", {31'h0, irq}, 0);
    evt(0, 1);
    chk(irq === 0, "R10 vbus ignored high", {31'h0, irq}, 0);
    repeat (2) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule